// File: doc/BRIEF.md
# Memory attribute remap decoder

This block resolves the compact attribute bits of a short-format page descriptor into a memory type and a shareability domain. Three descriptor bits (TEX[0], C, B) form an index into a programmable 32-bit remap control word. The control word holds a 2-bit memory type per index, one shareable bit for each value of the descriptor S bit, and one inner/outer domain bit per index.

Software loads the control word through a synchronous write port. The register coerces the fixed fields as it takes the write. The lookup itself is purely combinational from the held word and the descriptor inputs, so a translation result is ready in the same cycle as its descriptor bits.

A side input tells the block that a normal region is non-cacheable at both inner and outer level. Such regions, and all device regions, bypass the programmable shareability chain and report outer shareable. Type code 11 is flagged as reserved and replaced by a fixed result. Index 6 has no fixed meaning, so a separate flag reports each time it is used.

Top module: `mattr_remap_top`

## Requirements
- R1: After synchronous reset, the control word reads 0x0003_0000: bits 17:16 are 1 and every other bit is 0.
- R2: When `ctrl_we` is high at a clock edge, `ctrl_rdata` from the next cycle equals `ctrl_wdata` with bits 17:16 forced to 1 and bits 23:20 forced to 0. While `ctrl_we` is low, the word holds its value.
- R3: The index is n = {TEX[0], C, B}, with TEX[0] as the most significant bit. For a type field ctrl[2n+1:2n] other than 11, `mem_type` equals that field: 00 is device nGnRnE, 01 is device nGnRE, and 10 is normal.
- R4: A type field of 11 sets `rsv_enc` to 1 and returns `mem_type` = 10 with `is_shareable` = 0 and `is_inner` = 0.
- R5: Device memory (type 00 or 01) always reports `is_shareable` = 1 and `is_inner` = 0, whatever the S bit, bits 19:18 and bit 24+n hold.
- R6: Normal memory that is not non-cacheable at both levels reports `is_shareable` equal to ctrl bit 18 when S = 0 and to ctrl bit 19 when S = 1.
- R7: For such a normal region, `is_inner` equals ctrl bit 24+n when `is_shareable` is 1. A value of 1 means inner shareable and 0 means outer. When the region is non-shareable, `is_inner` is 0.
- R8: Normal memory with `both_noncache` = 1 reports `is_shareable` = 1 and `is_inner` = 0, ignoring bits 19:18 and 24+n.
- R9: `idx_impdef` is 1 exactly when n = 6.
- R10: `rsv_enc` is 0 whenever the selected type field is not 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Held control word |
| desc_tex0 | input | 1 | Descriptor TEX[0] bit (index MSB) |
| desc_c | input | 1 | Descriptor C bit |
| desc_b | input | 1 | Descriptor B bit (index LSB) |
| desc_s | input | 1 | Descriptor S bit |
| both_noncache | input | 1 | Normal region is non-cacheable at inner and outer level |
| mem_type | output | 2 | Resolved memory type (00, 01 device; 10 normal) |
| is_shareable | output | 1 | Region is shareable |
| is_inner | output | 1 | 1 inner shareable, 0 outer shareable |
| rsv_enc | output | 1 | Selected type field held the reserved code 11 |
| idx_impdef | output | 1 | Index 6 was selected |

## Verification
The bench builds the block with its default parameters: a 3-bit index over eight type fields in a 32-bit word, with the S-select bits at 18 and 19 and the domain bits from 24. These values make the full index space small enough to sweep completely. For several control words, every index is checked against both S values and both cacheability states, so every type code, the reserved substitution, both shareable selectors and each domain bit are compared against a model written from the requirements. Directed writes of all-ones and zero words expose the forced fields, and idle cycles with changing write data expose any leak through the hold path.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    localparam int CTRL_W    = 32;
    localparam int IDX_W     = 3;
    localparam int NUM_IDX   = 1 << IDX_W;
    localparam int TYPE_W    = 2;
    localparam int SH_S0_POS = 18;
    localparam int SH_S1_POS = 19;
    localparam int DOM_POS   = 24;
    localparam int ONE_LO    = 16;
    localparam int ONE_W     = 2;
    localparam int ZERO_LO   = 20;
    localparam int ZERO_W    = 4;
    localparam int ODD_IDX   = 6;

    typedef enum logic [TYPE_W-1:0] {
        MT_DEV_NGNRNE = 2'b00,
        MT_DEV_NGNRE  = 2'b01,
        MT_NORMAL     = 2'b10,
        MT_RSVD       = 2'b11
    } mtype_e;

    typedef struct packed {
        mtype_e kind;
        logic   share;
        logic   inner;
        logic   rsvd;
    } attr_res_t;

    function automatic logic is_device(input mtype_e k);
        return (k == MT_DEV_NGNRNE) || (k == MT_DEV_NGNRE);
    endfunction

endpackage

// File: rtl/mattr_ctrl_reg.sv
module mattr_ctrl_reg
    import mattr_pkg::*;
#(
    parameter int W       = CTRL_W,
    parameter int ONE_LSB = ONE_LO,
    parameter int ONE_N   = ONE_W,
    parameter int ZER_LSB = ZERO_LO,
    parameter int ZER_N   = ZERO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONES_MASK = ((W'(1) << ONE_N) - W'(1)) << ONE_LSB;
    localparam logic [W-1:0] ZERO_MASK = ((W'(1) << ZER_N) - W'(1)) << ZER_LSB;
    localparam logic [W-1:0] RESET_VAL = ONES_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (we) begin
            q <= (wdata | ONES_MASK) & ~ZERO_MASK;
        end
    end

    // R2: idle cycles leave the word untouched
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R2: the low type fields take the written data unchanged
    p_wr_low_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> q[ONE_LSB-1:0] == $past(wdata[ONE_LSB-1:0]));

    // R1, R2: forced fields keep their fixed values
    p_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        (q[ONE_LSB +: ONE_N] == '1) && (q[ZER_LSB +: ZER_N] == '0));

endmodule

// File: rtl/mattr_type_pick.sv
module mattr_type_pick
    import mattr_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int TW = TYPE_W,
    localparam int N = 1 << IW
) (
    input  logic [N*TW-1:0] fields,
    input  logic [IW-1:0]   idx,
    output logic [TW-1:0]   fld
);

    logic [TW-1:0] slot [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign slot[g] = fields[g*TW +: TW];
    end

    assign fld = slot[idx];

endmodule

// File: rtl/mattr_share_resolve.sv
module mattr_share_resolve
    import mattr_pkg::*;
#(
    parameter int IW = IDX_W,
    localparam int N = 1 << IW
) (
    input  logic [1:0]    sh_pair,
    input  logic [N-1:0]  dom_bits,
    input  logic [IW-1:0] idx,
    input  logic          s_bit,
    input  logic          both_nc,
    input  mtype_e        kind_raw,
    output attr_res_t     res
);

    logic dom_slot [N];
    logic sel_share;

    for (genvar g = 0; g < N; g++) begin : g_dom
        assign dom_slot[g] = dom_bits[g];
    end

    assign sel_share = s_bit ? sh_pair[1] : sh_pair[0];

    always_comb begin
        res = '0;
        res.kind = MT_NORMAL;
        case (kind_raw)
            MT_DEV_NGNRNE, MT_DEV_NGNRE: begin
                res.kind  = kind_raw;
                res.share = 1'b1;
                res.inner = 1'b0;
            end
            MT_NORMAL: begin
                res.share = both_nc | sel_share;
                res.inner = ~both_nc & sel_share & dom_slot[idx];
            end
            default: begin
                res.rsvd = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mattr_remap_top.sv
module mattr_remap_top
    import mattr_pkg::*;
#(
    parameter int W     = CTRL_W,
    parameter int IW    = IDX_W,
    parameter int TW    = TYPE_W,
    parameter int S0    = SH_S0_POS,
    parameter int S1    = SH_S1_POS,
    parameter int DOM   = DOM_POS,
    parameter int ODD   = ODD_IDX,
    localparam int N    = 1 << IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [W-1:0]  ctrl_wdata,
    output logic [W-1:0]  ctrl_rdata,
    input  logic          desc_tex0,
    input  logic          desc_c,
    input  logic          desc_b,
    input  logic          desc_s,
    input  logic          both_noncache,
    output logic [TW-1:0] mem_type,
    output logic          is_shareable,
    output logic          is_inner,
    output logic          rsv_enc,
    output logic          idx_impdef
);

    logic [W-1:0]  ctrl_q;
    logic [IW-1:0] idx;
    logic [TW-1:0] fld;
    attr_res_t     res;

    assign idx = {desc_tex0, desc_c, desc_b};

    mattr_ctrl_reg #(
        .W(W), .ONE_LSB(ONE_LO), .ONE_N(ONE_W), .ZER_LSB(ZERO_LO), .ZER_N(ZERO_W)
    ) u_reg (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata), .q(ctrl_q)
    );

    mattr_type_pick #(.IW(IW), .TW(TW)) u_pick (
        .fields(ctrl_q[N*TW-1:0]), .idx(idx), .fld(fld)
    );

    mattr_share_resolve #(.IW(IW)) u_share (
        .sh_pair({ctrl_q[S1], ctrl_q[S0]}),
        .dom_bits(ctrl_q[DOM +: N]),
        .idx(idx),
        .s_bit(desc_s),
        .both_nc(both_noncache),
        .kind_raw(mtype_e'(fld)),
        .res(res)
    );

    assign ctrl_rdata   = ctrl_q;
    assign mem_type     = res.kind;
    assign is_shareable = res.share;
    assign is_inner     = res.inner;
    assign rsv_enc      = res.rsvd;
    assign idx_impdef   = (idx == IW'(ODD));

    // R5: device types are always outer shareable
    p_dev_outer_r5: assert property (@(posedge clk) disable iff (rst)
        is_device(mtype_e'(mem_type)) |-> (is_shareable && !is_inner));

    // R4: reserved code yields the fixed substitute
    p_rsv_subst_r4: assert property (@(posedge clk) disable iff (rst)
        rsv_enc |-> (mem_type == MT_NORMAL && !is_shareable && !is_inner));

    // R10: reserved flag only for type field 11
    p_rsv_only_r10: assert property (@(posedge clk) disable iff (rst)
        rsv_enc |-> (fld == MT_RSVD));

    // R7: inner domain implies shareable
    p_inner_share_r7: assert property (@(posedge clk) disable iff (rst)
        is_inner |-> is_shareable);

    // R8: fully non-cacheable normal region is outer shareable
    p_nc_outer_r8: assert property (@(posedge clk) disable iff (rst)
        (both_noncache && mem_type == MT_NORMAL && !rsv_enc) |-> (is_shareable && !is_inner));

    // R9: odd-index flag tracks descriptor bits 1,1,0
    p_odd_flag_r9: assert property (@(posedge clk) disable iff (rst)
        idx_impdef |-> (desc_tex0 && desc_c && !desc_b));

endmodule

// File: tb/mattr_remap_top_tb.sv
`timescale 1ns/1ps
module mattr_remap_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctrl_we;
    logic [31:0] ctrl_wdata;
    logic [31:0] ctrl_rdata;
    logic        desc_tex0, desc_c, desc_b, desc_s, both_noncache;
    logic [1:0]  mem_type;
    logic        is_shareable, is_inner, rsv_enc, idx_impdef;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mattr_remap_top u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .desc_tex0(desc_tex0), .desc_c(desc_c),
        .desc_b(desc_b), .desc_s(desc_s), .both_noncache(both_noncache),
        .mem_type(mem_type), .is_shareable(is_shareable), .is_inner(is_inner),
        .rsv_enc(rsv_enc), .idx_impdef(idx_impdef)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {type[1:0], share, inner, rsv, odd} from the requirements
    function automatic logic [5:0] model(input logic [31:0] w, input int n,
                                         input logic s, input logic nc);
        logic [1:0] t;
        logic sh, inn, odd;
        t   = w[2*n +: 2];
        odd = (n == 6);
        if (t == 2'b11)      return {2'b10, 1'b0, 1'b0, 1'b1, odd};
        else if (t != 2'b10) return {t, 1'b1, 1'b0, 1'b0, odd};
        else if (nc)         return {2'b10, 1'b1, 1'b0, 1'b0, odd};
        sh  = s ? w[19] : w[18];
        inn = sh & w[24+n];
        return {2'b10, sh, inn, 1'b0, odd};
    endfunction

    function automatic logic [5:0] outs();
        return {mem_type, is_shareable, is_inner, rsv_enc, idx_impdef};
    endfunction

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic drive(input int n, input logic s, input logic nc);
        {desc_tex0, desc_c, desc_b} = 3'(n);
        desc_s = s;
        both_noncache = nc;
        #1;
    endtask

    task automatic sweep(input string tag, input logic [31:0] w);
        wr(w);
        for (int n = 0; n < 8; n++) begin
            for (int s = 0; s < 2; s++) begin
                for (int nc = 0; nc < 2; nc++) begin
                    drive(n, 1'(s), 1'(nc));
                    chk($sformatf("%s n=%0d s=%0d nc=%0d", tag, n, s, nc),
                        32'(outs()), 32'(model(w, n, 1'(s), 1'(nc))));
                end
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        ctrl_we = 1'b0;
        ctrl_wdata = 32'hFFFF_FFFF;
        drive(0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", ctrl_rdata, 32'h0003_0000);
        drive(0, 1'b1, 1'b0);
        chk("R1 R5 reset decode", 32'(outs()), 32'({2'b00, 1'b1, 1'b0, 1'b0, 1'b0}));
    endtask

    task automatic t_write();
        wr(32'hFFFF_FFFF);
        chk("R2 all-ones write", ctrl_rdata, 32'hFF0F_FFFF);
        wr(32'h0000_0000);
        chk("R2 zero write", ctrl_rdata, 32'h0003_0000);
        wr(32'h12F4_5678);
        chk("R2 mixed write", ctrl_rdata, 32'h1207_5678);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ctrl_wdata = 32'hDEAD_BEEF ^ 32'(k);
        end
        @(negedge clk);
        chk("R2 hold without enable", ctrl_rdata, 32'h1207_5678);
    endtask

    task automatic t_odd();
        wr(32'h0000_AAAA);
        drive(6, 1'b0, 1'b0);
        chk("R9 index 6 flag", 32'(idx_impdef), 32'd1);
        drive(7, 1'b0, 1'b0);
        chk("R9 index 7 flag", 32'(idx_impdef), 32'd0);
        drive(2, 1'b0, 1'b0);
        chk("R9 index 2 flag", 32'(idx_impdef), 32'd0);
    endtask

    task automatic t_noncache();
        wr(32'hFF0C_AAAA);
        drive(3, 1'b1, 1'b1);
        chk("R8 nc overrides inner", 32'({is_shareable, is_inner}), 32'b10);
        wr(32'h0000_AAAA);
        drive(5, 1'b0, 1'b1);
        chk("R8 nc overrides non-shareable", 32'({is_shareable, is_inner}), 32'b10);
    endtask

    initial begin
        t_reset();
        t_write();
        sweep("R3 R10 mixed types", 32'h5A08_E41B);
        sweep("R6 R7 normal s0 shareable", 32'hA504_AAAA);
        sweep("R7 normal both shareable", 32'hFF0C_AAAA);
        sweep("R4 all reserved", 32'hFF0C_FFFF);
        sweep("R5 device only", 32'hFF0C_5500);
        t_odd();
        t_noncache();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule